// File: doc/BRIEF.md
# Write Leveling Tap Sweep Controller

This block trains the write strobe delay of a memory interface, one byte lane after another. A start pulse clears every lane's delay code to zero and begins training lane 0. The strobe enable stays high the whole time. At each tap the block waits a fixed settle time so that the new delay can take effect. It then issues a one-cycle readback request and waits for the DRAM's report, which says whether the strobe's rising edge arrives ahead of or behind the clock edge that the DRAM samples with.

A lane is aligned when the report at the current tap differs from the report at the previous tap. The clock edge has then been crossed, so the lane keeps its current code. When the report does not change, the code moves up by one tap and the settle/request cycle starts again. If the code reaches the top tap and the report still has not changed, the lane is marked as failed and keeps the top code. When the last lane has finished, whether it passed or failed, the block raises its done flag and drops the strobe enable.

Top module: `wrlvl_sweep`

## Requirements
- R1: While reset is held, and on the cycle after it is released, every lane's tap code is 0, the error bits are 0, and done, strobe enable and readback request are all low.
- R2: A start pulse taken while idle clears all tap codes, error bits and done, and selects lane 0. Strobe enable is high from the next cycle until training ends.
- R3: After a lane begins, and after every tap change, the readback request goes high for exactly one cycle, and only after SETTLE full cycles have passed with no request.
- R4: When a report matches the previous report for that lane, or is the lane's first report, the current lane's tap code rises by exactly 1. No other lane's code changes.
- R5: When a report differs from the previous report of the same lane, that lane stops at its current tap and its error bit stays 0.
- R6: When the code is 31 (the top of the 5-bit range) and the report matches the previous one, the lane's error bit is set and its code stays 31.
- R7: Lanes are trained in ascending order 0 to LANES-1. The lane select output shows the lane being trained. Lane i's code occupies bits [5i+4:5i] of the tap code bus.
- R8: Done rises in the cycle after the last lane's final report, at the same moment that strobe enable falls. Done and all codes then hold until the next start.
- R9: A readback-valid pulse that arrives while no request is outstanding has no effect. A start pulse during training has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin training pulse |
| rb_valid | input | 1 | Readback report valid |
| rb_lead | input | 1 | Report: 1 = strobe ahead of clock, 0 = behind |
| strobe_en | output | 1 | Strobe toggle enable during training |
| rb_req | output | 1 | One-cycle mode-register readback request |
| lane_sel | output | LW | Lane currently being trained |
| tap_codes | output | LANES*TAP_W | Packed per-lane tap codes |
| lane_err | output | LANES | Per-lane failure flags |
| done | output | 1 | All lanes finished |

## Verification
The bench sets an alignment tap for each lane and answers every readback request after a fixed latency. The lanes include one that crosses at tap 1, one that crosses only at tap 31, and ones whose report never changes. A design that checks for tap 31 before it checks for a report change would wrongly fail the tap-31 lane, and a design off by one in the settle count would issue its request a cycle early or late. Stray valid pulses and mid-training start pulses are injected; a design that consumed them would advance taps or restart lanes. Both report polarities are used, so a design that looks for only one direction of change would never align.

// File: rtl/wrlvl_sweep.sv
module wrlvl_sweep #(
  parameter int LANES  = 4,
  parameter int TAP_W  = 5,
  parameter int SETTLE = 6,
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   rb_valid,
  input  logic                   rb_lead,
  output logic                   strobe_en,
  output logic                   rb_req,
  output logic [LW-1:0]          lane_sel,
  output logic [LANES*TAP_W-1:0] tap_codes,
  output logic [LANES-1:0]       lane_err,
  output logic                   done
);
  localparam int CW = $clog2(SETTLE + 1);
  localparam logic [TAP_W-1:0] TAP_TOP = '1;

  typedef enum logic [1:0] {ST_IDLE, ST_SETL, ST_REQ, ST_WAIT} st_t;

  st_t             st;
  logic [CW-1:0]   cnt;
  logic [LW-1:0]   lane;
  logic            prev, first;
  logic [TAP_W-1:0] tap_q [LANES];
  logic [TAP_W-1:0] cur_tap;
  logic            flipped, lane_end, last_lane;

  assign cur_tap   = tap_q[lane];
  assign flipped   = !first && (rb_lead != prev);
  assign lane_end  = flipped || (cur_tap == TAP_TOP);
  assign last_lane = (lane == LW'(LANES - 1));
  assign strobe_en = (st != ST_IDLE);
  assign rb_req    = (st == ST_REQ);
  assign lane_sel  = lane;

  for (genvar g = 0; g < LANES; g++) begin : g_pack
    assign tap_codes[g*TAP_W +: TAP_W] = tap_q[g];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cnt      <= '0;
      lane     <= '0;
      prev     <= 1'b0;
      first    <= 1'b1;
      lane_err <= '0;
      done     <= 1'b0;
      for (int i = 0; i < LANES; i++) tap_q[i] <= '0;
    end else begin
      case (st)
        ST_IDLE: if (start) begin
          for (int i = 0; i < LANES; i++) tap_q[i] <= '0;
          lane_err <= '0;
          done     <= 1'b0;
          lane     <= '0;
          first    <= 1'b1;
          cnt      <= '0;
          st       <= ST_SETL;
        end
        ST_SETL: begin
          if (cnt == CW'(SETTLE - 1)) begin
            cnt <= '0;
            st  <= ST_REQ;
          end else cnt <= cnt + 1'b1;
        end
        ST_REQ: st <= ST_WAIT;
        ST_WAIT: if (rb_valid) begin
          if (lane_end) begin
            if (!flipped) lane_err[lane] <= 1'b1;
            if (last_lane) begin
              done <= 1'b1;
              st   <= ST_IDLE;
            end else begin
              lane  <= lane + 1'b1;
              first <= 1'b1;
              st    <= ST_SETL;
            end
          end else begin
            tap_q[lane] <= cur_tap + 1'b1;
            prev        <= rb_lead;
            first       <= 1'b0;
            st          <= ST_SETL;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wrlvl_sweep_chk.sv
module wrlvl_sweep_chk #(
  parameter int LANES = 4,
  parameter int TAP_W = 5,
  parameter int LW    = 2
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   start,
  input logic                   strobe_en,
  input logic                   rb_req,
  input logic [LANES*TAP_W-1:0] tap_codes,
  input logic [LANES-1:0]       lane_err,
  input logic                   done
);
  p_req_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rb_req |=> !rb_req);

  p_req_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rb_req |-> strobe_en);

  p_done_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !strobe_en);

  p_done_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    p_tap_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (strobe_en && !done) |=>
        (tap_codes[g*TAP_W +: TAP_W] == $past(tap_codes[g*TAP_W +: TAP_W]) ||
         tap_codes[g*TAP_W +: TAP_W] == $past(tap_codes[g*TAP_W +: TAP_W]) + 1'b1));

    p_err_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lane_err[g] |-> (tap_codes[g*TAP_W +: TAP_W] == '1));
  end
endmodule

bind wrlvl_sweep wrlvl_sweep_chk #(.LANES(LANES), .TAP_W(TAP_W), .LW(LW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .strobe_en(strobe_en),
  .rb_req(rb_req), .tap_codes(tap_codes), .lane_err(lane_err), .done(done));

// File: tb/tb_wrlvl_sweep.sv
`timescale 1ns/1ps
module tb_wrlvl_sweep;
  localparam int LANES = 4, TAP_W = 5, SETTLE = 6, LW = 2, RB_LAT = 3;

  logic clk = 0, rst_n = 0, start = 0, rb_valid = 0, rb_lead = 0;
  logic strobe_en, rb_req, done;
  logic [LW-1:0] lane_sel;
  logic [LANES*TAP_W-1:0] tap_codes;
  logic [LANES-1:0] lane_err;

  wrlvl_sweep #(.LANES(LANES), .TAP_W(TAP_W), .SETTLE(SETTLE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rb_valid(rb_valid), .rb_lead(rb_lead),
    .strobe_en(strobe_en), .rb_req(rb_req), .lane_sel(lane_sel),
    .tap_codes(tap_codes), .lane_err(lane_err), .done(done));

  always #5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  int edge_tap [LANES];
  int pol = 0, spur = 0, cyc = 0, pending = 0;

  // behavioural reference (phase: 0 idle, 1 settle, 2 request, 3 waiting)
  int m_ph = 0, m_wait = 0, m_lane = 0, m_done = 0, m_last = -1;
  int m_tap [LANES] = '{default: 0};
  int m_err [LANES] = '{default: 0};

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_wait = 0; m_lane = 0; m_done = 0; m_last = -1;
      for (int i = 0; i < LANES; i++) begin m_tap[i] = 0; m_err[i] = 0; end
    end else begin
      case (m_ph)
        0: if (start) begin
             for (int i = 0; i < LANES; i++) begin m_tap[i] = 0; m_err[i] = 0; end
             m_done = 0; m_lane = 0; m_last = -1; m_ph = 1; m_wait = SETTLE;
           end
        1: begin m_wait--; if (m_wait == 0) m_ph = 2; end
        2: m_ph = 3;
        3: if (rb_valid) begin
             int rep;
             rep = rb_lead;
             if ((m_last >= 0 && rep != m_last) || m_tap[m_lane] == 31) begin
               if (!(m_last >= 0 && rep != m_last)) m_err[m_lane] = 1;
               if (m_lane == LANES - 1) begin m_done = 1; m_ph = 0; end
               else begin m_lane++; m_last = -1; m_ph = 1; m_wait = SETTLE; end
             end else begin
               m_tap[m_lane]++; m_last = rep; m_ph = 1; m_wait = SETTLE;
             end
           end
        default: m_ph = 0;
      endcase
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    chk("R2/R8", "strobe_en", strobe_en, (m_ph != 0));
    chk("R3", "rb_req", rb_req, (m_ph == 2));
    chk("R8", "done", done, m_done);
    chk("R7", "lane_sel", lane_sel, m_lane);
    for (int i = 0; i < LANES; i++) begin
      chk("R4/R5", "tap", int'(tap_codes[i*TAP_W +: TAP_W]), m_tap[i]);
      chk("R6", "err", lane_err[i], m_err[i]);
    end
    // DRAM responder: report after RB_LAT cycles; stray valids when idle
    rb_valid = 0;
    if (pending > 0) begin
      pending--;
      if (pending == 0) begin
        int t;
        t = int'(tap_codes[lane_sel*TAP_W +: TAP_W]);
        rb_valid = 1;
        rb_lead = pol[0] ^ (t >= edge_tap[lane_sel]);
      end
    end else if (spur != 0 && (cyc % 5 == 0)) begin
      rb_valid = 1;  // R9 stray report
      rb_lead = cyc[3];
    end
    if (rb_req) pending = RB_LAT;
  end

  task automatic pulse_start;
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic final_check;
    for (int i = 0; i < LANES; i++) begin
      int e;
      e = (edge_tap[i] >= 1 && edge_tap[i] <= 31) ? edge_tap[i] : 31;
      chk("R5/R6", "final tap", int'(tap_codes[i*TAP_W +: TAP_W]), e);
      chk("R6", "final err", lane_err[i], !(edge_tap[i] >= 1 && edge_tap[i] <= 31));
    end
    chk("R8", "done held", done, 1);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: run hung, actual=running expected=finished");
    summary();
  end

  initial begin
    edge_tap = '{5, 0, 31, 12};
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk("R1", "reset taps", int'(tap_codes), 0);
    // scenario 1: mixed lanes, lead polarity 0
    pulse_start();
    wait (done === 1'b1);
    repeat (5) @(negedge clk);
    final_check();
    // scenario 2: inverted polarity, stray valids, start during training
    pol = 1; spur = 1;
    edge_tap = '{1, 32, 7, 3};
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();   // R9: ignored while busy
    wait (done === 1'b1);
    repeat (20) @(negedge clk);
    final_check();
    // scenario 3: restart clears and retrains (R2)
    spur = 0; pol = 0;
    edge_tap = '{2, 3, 4, 31};
    pulse_start();
    chk("R2", "done cleared", done, 0);
    wait (done === 1'b1);
    repeat (3) @(negedge clk);
    final_check();
    summary();
  end
endmodule